// File: doc/BRIEF.md
# Multi-Level Vectored Interrupt Controller

This block gathers thirteen interrupt sources into nine vectored requests and picks the one the processor should take next. Four of the vectors are shared by two sources each, so their request is the OR of both members. Every vector has an enable bit and one priority bit. On the two highest external inputs the priority bit selects the top tier. On every other vector it selects the middle tier. When the bit is clear, the vector sits in the bottom tier.

The four external pins are conditioned inside the block. The first two pins detect edges or levels. The other two detect edges only, and they can also detect both edges. An edge is stored in a sticky flag until software clears it. A level request follows the pin for as long as the pin holds its active value. Handlers can nest. Acknowledging a request pushes its tier onto an in-service stack, and a return-from-interrupt pops the stack. A new request is raised only when its tier is strictly above the tier of the handler now in service.

The internal sources arrive as flags that their own peripherals already hold. The block keeps no processor context.

Top module: `vic_top`

## Requirements
- R1: After reset, `irq` is 0, `irq_vec` and `irq_addr` are 0, `cur_level` is 0 and `nest_depth` is 0. A pin that is already high when reset is released causes no edge event.
- R2: Vector requests are mapped as follows: v1=pin0, v2=pin1, v3=pin2 OR `int_src[0]`, v4=pin3 OR `int_src[1]`, v5=`int_src[2]`, v6=`int_src[3]` OR `int_src[4]`, v7=`int_src[5]`, v8=`int_src[6]`, v9=`int_src[7]` OR `int_src[8]`. Vector n uses bit n-1 of `vec_en` and of `vec_pri`.
- R3: `irq_addr` equals 8*(n-1)+3 for the presented vector n, so v1=03h, v3=13h, v4=1Bh and v9=43h. While `irq` is 0, `irq_vec` and `irq_addr` read 0.
- R4: Tier codes are 1=low, 2=high and 3=top. A vector with its priority bit clear is low. With the bit set, v1 and v2 are top and v3..v9 are high.
- R5: Among pending, enabled vectors, the highest tier wins. Within a tier, the lowest vector number wins.
- R6: `irq` is 1 only when the winning tier is strictly greater than `cur_level`. A disabled vector never wins.
- R7: An `ack` while `irq` is 1 pushes the winning tier. `nest_depth` then rises by one and `cur_level` becomes that tier.
- R8: `reti` pops one level and restores the tier below it. A `reti` at depth 0 has no effect. If `ack` (while `irq`=1) and `reti` arrive in the same cycle, the top entry is replaced by the new tier and the depth is unchanged.
- R9: The pin0/pin1 mode codes are 00 rising edge, 01 falling edge, 10 low level and 11 high level. A level request follows the pin one clock after the pin changes.
- R10: The pin2/pin3 mode codes are 00 rising edge, 01 falling edge and 1x both edges. An edge that does not match the mode is ignored.
- R11: An edge flag is set at the clock edge that follows the pin transition and stays set until its `ext_clr` bit is pulsed. If a new edge and a clear arrive in the same cycle, the flag stays set.
- R12: An `ack` while `irq` is 0 leaves `nest_depth` and `cur_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 4 | External interrupt pins 0..3 |
| pin_mode | input | 8 | Two mode bits per pin, pin k at bits 2k+1:2k |
| ext_clr | input | 4 | Software clear of the pin edge flags |
| int_src | input | 9 | Internal source flags (mapping in R2) |
| vec_en | input | 9 | Per-vector enable |
| vec_pri | input | 9 | Per-vector priority bit |
| ack | input | 1 | Processor takes the presented request |
| reti | input | 1 | Return from the current handler |
| irq | output | 1 | Interrupt request to the processor |
| irq_vec | output | 4 | Presented vector number 1..9, or 0 |
| irq_addr | output | 8 | Vector address of the presented vector |
| cur_level | output | 2 | Tier of the handler in service (0 = none) |
| nest_depth | output | 2 | Number of nested handlers in service |

## Verification
Two functions can fall in the same cycle. The first is an acknowledge and a return together. The bench provokes it by returning from a high-tier handler while a top-tier request is waiting, and it checks that the depth stays put while the in-service tier jumps to the top. The second is a pin edge that lands in the same cycle as a software clear of that pin's flag. The bench drives both in one cycle and checks that the request survives. Arbitration is swept over all 512 request masks under four priority and enable patterns, and the expected winner is recomputed in the bench from the tier rules.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_VEC  = 9;
  localparam int NUM_PIN  = 4;
  localparam int NUM_ISRC = 9;
  localparam int VEC_W    = 4;
  localparam int ADDR_W   = 8;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;

  // vector n (1-based) sits at 8*(n-1)+3
  function automatic logic [ADDR_W-1:0] vec_addr(input logic [VEC_W-1:0] n);
    logic [ADDR_W-1:0] base;
    base = ADDR_W'(n) - ADDR_W'(1);
    return (base << 3) + ADDR_W'(3);
  endfunction

  // idx is 0-based; the first two vectors may reach the top tier
  function automatic lvl_t vec_level(input int idx, input logic pri);
    if (!pri) return LVL_LOW;
    return (idx < 2) ? LVL_TOP : LVL_HIGH;
  endfunction
endpackage

// File: rtl/vic_pin_cond.sv
module vic_pin_cond #(
  parameter bit LEVEL_OK = 1'b1,
  parameter bit BOTH_OK  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  input  logic       clr,
  output logic       req,
  output logic       edge_hit
);
  logic pin_q, armed_q, flag_q;
  logic rise, fall, is_level, level_hit;

  assign rise = armed_q & pin & ~pin_q;
  assign fall = armed_q & ~pin & pin_q;

  generate
    if (LEVEL_OK) begin : g_lvl
      assign is_level  = mode[1];
      assign edge_hit  = mode[1] ? 1'b0 : (mode[0] ? fall : rise);
      assign level_hit = mode[0] ? pin_q : ~pin_q;
    end else begin : g_edge
      logic both_sel;
      assign both_sel  = BOTH_OK & mode[1];
      assign is_level  = 1'b0;
      assign edge_hit  = both_sel ? (rise | fall) : (mode[0] ? fall : rise);
      assign level_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pin_q   <= pin;
      armed_q <= 1'b1;
      if (edge_hit)  flag_q <= 1'b1;
      else if (clr)  flag_q <= 1'b0;
    end
  end

  assign req = is_level ? level_hit : flag_q;

  assert_edge_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> flag_q);
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  assert_clear_wins_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_hit) |=> !flag_q);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
(
  input  logic [NUM_VEC-1:0] pend,
  input  logic [NUM_VEC-1:0] en,
  input  logic [NUM_VEC-1:0] pri,
  output logic [NUM_VEC-1:0] grant,
  output lvl_t               best_lvl,
  output logic [VEC_W-1:0]   best_vec
);
  lvl_t lvl [NUM_VEC];

  generate
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_lvl
      assign lvl[i] = vec_level(i, pri[i]);
    end
  endgenerate

  always_comb begin
    best_lvl = LVL_NONE;
    best_vec = '0;
    grant    = '0;
    // walk downward so an equal tier at a lower number overrides
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pend[i] && en[i] && lvl[i] >= best_lvl) begin
        best_lvl = lvl[i];
        best_vec = VEC_W'(i + 1);
      end
    end
    if (best_vec != '0) grant[best_vec - VEC_W'(1)] = 1'b1;
  end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack
  import vic_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  lvl_t          push_lvl,
  output lvl_t          cur_lvl,
  output logic [DW-1:0] depth,
  output logic          full
);
  lvl_t          stk [DEPTH];
  logic [DW-1:0] top_idx;
  logic          pop_ok;

  assign top_idx = depth - DW'(1);
  assign pop_ok  = pop && (depth != '0);
  assign full    = (depth == DW'(DEPTH));
  assign cur_lvl = (depth == '0) ? LVL_NONE : stk[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= LVL_NONE;
    end else if (push && pop_ok) begin
      stk[top_idx] <= push_lvl;
    end else if (push && !full) begin
      stk[depth] <= push_lvl;
      depth      <= depth + DW'(1);
    end else if (pop_ok) begin
      depth <= top_idx;
    end
  end

  assert_push_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full) |=> depth == $past(depth) + DW'(1));
  assert_pop_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push) |=> depth == $past(depth) - DW'(1));
  assert_push_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && (pop_ok || !full)) |=> cur_lvl == $past(push_lvl));
  assert_both_keep_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_ok) |=> $stable(depth));
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NEST_DEPTH = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [3:0]                      ext_pin,
  input  logic [7:0]                      pin_mode,
  input  logic [3:0]                      ext_clr,
  input  logic [8:0]                      int_src,
  input  logic [8:0]                      vec_en,
  input  logic [8:0]                      vec_pri,
  input  logic                            ack,
  input  logic                            reti,
  output logic                            irq,
  output logic [3:0]                      irq_vec,
  output logic [7:0]                      irq_addr,
  output logic [1:0]                      cur_level,
  output logic [$clog2(NEST_DEPTH+1)-1:0] nest_depth
);
  localparam int DW = $clog2(NEST_DEPTH + 1);

  logic [NUM_PIN-1:0] pin_req, pin_edge;
  logic [NUM_VEC-1:0] pend, grant;
  lvl_t               best_lvl, in_service;
  logic [VEC_W-1:0]   best_vec;
  logic               stk_full, take;

  generate
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      vic_pin_cond #(
        .LEVEL_OK (p < 2),
        .BOTH_OK  (p >= 2)
      ) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin[p]),
        .mode     (pin_mode[2*p +: 2]),
        .clr      (ext_clr[p]),
        .req      (pin_req[p]),
        .edge_hit (pin_edge[p])
      );
    end
  endgenerate

  // shared vectors OR their two members together
  assign pend[0] = pin_req[0];
  assign pend[1] = pin_req[1];
  assign pend[2] = pin_req[2] | int_src[0];
  assign pend[3] = pin_req[3] | int_src[1];
  assign pend[4] = int_src[2];
  assign pend[5] = int_src[3] | int_src[4];
  assign pend[6] = int_src[5];
  assign pend[7] = int_src[6];
  assign pend[8] = int_src[7] | int_src[8];

  vic_arbiter u_arb (
    .pend     (pend),
    .en       (vec_en),
    .pri      (vec_pri),
    .grant    (grant),
    .best_lvl (best_lvl),
    .best_vec (best_vec)
  );

  assign irq  = (best_lvl > in_service) && !stk_full;
  assign take = ack && irq;

  vic_nest_stack #(.DEPTH(NEST_DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (take),
    .pop      (reti),
    .push_lvl (best_lvl),
    .cur_lvl  (in_service),
    .depth    (nest_depth),
    .full     (stk_full)
  );

  assign cur_level = in_service;
  assign irq_vec   = irq ? best_vec : '0;
  assign irq_addr  = irq ? vec_addr(best_vec) : '0;

  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~(pend & vec_en)) == '0);
  assert_irq_has_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_vec != '0 && irq_addr[2:0] == 3'b011));
  assert_idle_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !reti) |=> ($stable(nest_depth) && $stable(cur_level)));
  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= DW'(NEST_DEPTH));
endmodule

// File: tb/vic_top_tb.sv
module vic_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_pin = '0;
  logic [7:0] pin_mode = '0;
  logic [3:0] ext_clr = '0;
  logic [8:0] int_src = '0;
  logic [8:0] vec_en = '0;
  logic [8:0] vec_pri = '0;
  logic       ack = 1'b0;
  logic       reti = 1'b0;
  logic       irq;
  logic [3:0] irq_vec;
  logic [7:0] irq_addr;
  logic [1:0] cur_level;
  logic [1:0] nest_depth;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vic_top u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pin_mode(pin_mode),
    .ext_clr(ext_clr), .int_src(int_src), .vec_en(vec_en), .vec_pri(vec_pri),
    .ack(ack), .reti(reti), .irq(irq), .irq_vec(irq_vec), .irq_addr(irq_addr),
    .cur_level(cur_level), .nest_depth(nest_depth)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_ack(input bit with_reti);
    @(negedge clk); ack = 1'b1; reti = with_reti;
    @(posedge clk); #1; ack = 1'b0; reti = 1'b0;
  endtask

  task automatic pulse_reti();
    @(negedge clk); reti = 1'b1;
    @(posedge clk); #1; reti = 1'b0;
  endtask

  task automatic pulse_clr(input logic [3:0] m);
    @(negedge clk); ext_clr = m;
    @(posedge clk); #1; ext_clr = '0;
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk); ext_pin[p] = v;
    @(posedge clk); #1;
  endtask

  // expected presentation: {irq, vec, addr}
  function automatic logic [12:0] expect_out(input logic [8:0] req, input logic [8:0] en,
                                             input logic [8:0] pri, input int cur);
    int best = 0, who = 0;
    for (int v = 1; v <= 9; v++) begin
      int t;
      t = !pri[v-1] ? 1 : (v <= 2 ? 3 : 2);
      if (req[v-1] && en[v-1] && t > best) begin best = t; who = v; end
    end
    if (best > cur) return {1'b1, 4'(who), 8'(8 * who - 5)};
    return 13'd0;
  endfunction

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    ext_pin[2] = 1'b1;   // high through reset, rising mode
    vec_en = 9'h004;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 irq", irq, 0); check("R1 vec", irq_vec, 0); check("R1 addr", irq_addr, 0);
    check("R1 level", cur_level, 0); check("R1 depth", nest_depth, 0);
    step(); step();
    check("R1 no edge from reset value", irq, 0);
    set_pin(2, 1'b0);
    check("R10 falling ignored in rising mode", irq, 0);

    // pin2 both edges
    pin_mode = 8'h20;
    set_pin(2, 1'b1);
    check("R10 both rise", {irq, irq_vec, irq_addr}, {1'b1, 4'd3, 8'h13});
    pulse_clr(4'h4);
    check("R11 cleared", irq, 0);
    set_pin(2, 1'b0);
    check("R10 both fall", irq, 1);
    pulse_clr(4'h4);
    pin_mode = 8'h10;
    set_pin(2, 1'b1);
    check("R10 rise ignored in falling mode", irq, 0);
    set_pin(2, 1'b0);
    check("R10 falling mode", irq, 1);
    pulse_clr(4'h4);
    // edge and clear together: set wins
    pin_mode = 8'h00;
    @(negedge clk); ext_pin[2] = 1'b1; ext_clr = 4'h4;
    step(); ext_clr = '0;
    check("R11 set wins over clear", irq, 1);
    pulse_clr(4'h4);
    set_pin(2, 1'b0);

    // pin3 rising on vector 4
    vec_en = 9'h008;
    set_pin(3, 1'b1);
    check("R3 pin3 vector addr", {irq, irq_vec, irq_addr}, {1'b1, 4'd4, 8'h1B});
    pulse_clr(4'h8);
    set_pin(3, 1'b0);

    // pin0 modes
    vec_en = 9'h001;
    set_pin(0, 1'b1);
    check("R9 rising", {irq, irq_vec, irq_addr}, {1'b1, 4'd1, 8'h03});
    set_pin(0, 1'b0);
    check("R11 sticky after pin drops", irq, 1);
    pulse_clr(4'h1);
    check("R11 clear", irq, 0);
    pin_mode = 8'h01;
    set_pin(0, 1'b1);
    check("R9 rise ignored in falling mode", irq, 0);
    set_pin(0, 1'b0);
    check("R9 falling", irq, 1);
    pulse_clr(4'h1);
    @(negedge clk); pin_mode = 8'h02; step();
    check("R9 low level active", irq, 1);
    set_pin(0, 1'b1);
    check("R9 low level released", irq, 0);
    @(negedge clk); pin_mode = 8'h03; step();
    check("R9 high level active", irq, 1);
    set_pin(0, 1'b0);
    check("R9 high level released", irq, 0);

    // arbitration sweep: pins 0,1 in high-level mode
    pin_mode = 8'h0F;
    for (int pat = 0; pat < 4; pat++) begin
      for (int m = 0; m < 512; m++) begin
        logic [8:0] mk, s, en, pr;
        mk = 9'(m);
        en = (pat == 3) ? (9'h1FF & ~9'h0A5) : 9'h1FF;
        pr = (pat == 0) ? 9'h000 : (pat == 1) ? 9'h1FF : (pat == 2) ? 9'h155 : 9'h0F0;
        s = '0;
        s[0] = mk[2]; s[1] = mk[3]; s[2] = mk[4];
        if (mk[5]) s[mk[0] ? 3 : 4] = 1'b1;
        s[5] = mk[6]; s[6] = mk[7];
        if (mk[8]) s[mk[1] ? 7 : 8] = 1'b1;
        @(negedge clk);
        ext_pin[0] = mk[0]; ext_pin[1] = mk[1];
        int_src = s; vec_en = en; vec_pri = pr;
        step();
        check("R2 R4 R5 R6 sweep", {irq, irq_vec, irq_addr}, expect_out(mk, en, pr, 0));
      end
    end
    @(negedge clk); ext_pin = '0; int_src = '0; vec_pri = '0; vec_en = 9'h1FF;
    step();

    // nesting
    @(negedge clk); vec_pri = 9'h041; int_src[3] = 1'b1; step();
    check("R4 low vec6", {irq, irq_vec, irq_addr}, {1'b1, 4'd6, 8'h2B});
    pulse_ack(0);
    check("R7 push low", {cur_level, nest_depth, irq}, {2'd1, 2'd1, 1'b0});
    @(negedge clk); int_src[5] = 1'b1; step();
    check("R6 high preempts low", {irq, irq_vec, irq_addr}, {1'b1, 4'd7, 8'h33});
    pulse_ack(0);
    check("R7 push high", {cur_level, nest_depth}, {2'd2, 2'd2});
    set_pin(0, 1'b1);
    check("R4 top vec1", {irq, irq_vec, irq_addr}, {1'b1, 4'd1, 8'h03});
    pulse_ack(0);
    check("R6 nothing above top", {cur_level, nest_depth, irq}, {2'd3, 2'd3, 1'b0});
    pulse_reti();
    check("R8 pop to high", {cur_level, nest_depth, irq, irq_vec}, {2'd2, 2'd2, 1'b1, 4'd1});
    pulse_ack(1);
    check("R8 ack with reti replaces", {cur_level, nest_depth, irq}, {2'd3, 2'd2, 1'b0});
    @(negedge clk); ext_pin[0] = 1'b0; reti = 1'b1; step(); reti = 1'b0;
    check("R8 pop to low", {cur_level, nest_depth, irq, irq_vec}, {2'd1, 2'd1, 1'b1, 4'd7});
    @(negedge clk); int_src = '0; step();
    pulse_reti();
    check("R8 empty", {cur_level, nest_depth, irq}, {2'd0, 2'd0, 1'b0});
    pulse_reti();
    check("R8 reti at depth 0", nest_depth, 0);
    pulse_ack(0);
    check("R12 ack without irq", {cur_level, nest_depth}, {2'd0, 2'd0});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule